// File: doc/BRIEF.md
# Translation-Off Attribute Generator

This block produces the result of a memory access while stage-1 address translation is switched off. The physical address equals the virtual address, but the virtual address must still be checked against the implemented physical address size. Each request carries a 64-bit virtual address, an access type, a code for the physical address size, top-byte-ignore enables with fetch-disable masks for the lower and upper address halves, two data-cache control bits, an instruction-cache enable and a flag that marks the EL1 regime.

One cycle after a request the block returns a registered result with a valid strobe. The result is either a level-0 address-size fault or a flat-mapped 52-bit physical address with full permissions, an 8-bit memory attribute and a 2-bit shareability code. The attribute is picked by priority. The data-cache force in the EL1 regime comes first, then instruction fetch, then the strongly-ordered device default.

Top module: `xlat_off_attr_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after reset, `rsp_valid`, `rsp_fault`, `rsp_pa`, `rsp_perm`, `rsp_attr` and `rsp_sh` are all zero.
- R2: A request sampled with `req_valid` high at a clock edge gives its result, with `rsp_valid` high, after that edge. `rsp_valid` is low after any edge where `req_valid` was low, and the other outputs then keep their values.
- R3: `req_pa_code` selects the physical address size: 0→32, 1→36, 2→40, 3→42, 4→44, 5→48, 6 and 7→52 bits. An address fits only if every bit from that size up to the top checked bit is zero.
- R4: The top-byte-ignore enable is `req_tbi_hi` when address bit 55 is 1 and `req_tbi_lo` when it is 0. When the enable applies, the top checked bit is 55, so bits 63:56 are ignored. Otherwise it is 63.
- R5: For an instruction fetch (`req_acc` = 2), the enable chosen in R4 is cleared when the fetch-disable bit of the same half (`req_tbid_hi` or `req_tbid_lo`) is set. For other access types the fetch-disable bits have no effect.
- R6: An address that fails the check gives `rsp_fault` = 1 (an address-size fault at level 0) with `rsp_pa`, `rsp_perm`, `rsp_attr` and `rsp_sh` all zero.
- R7: An address that passes gives `rsp_fault` = 0, `rsp_pa` = address bits 51:0, and `rsp_perm` = 3'b111 (bit 0 read, bit 1 write, bit 2 execute).
- R8: When `req_regime_el1` and `req_dc_force` are both 1, the attribute is 8'hF0 if `req_dc_tagged` is 1 and 8'hFF otherwise, with shareability 0, for any access type. With `req_regime_el1` = 0, the data-cache bits have no effect.
- R9: Otherwise an instruction fetch gives attribute 8'hEE if `req_icache_on` is 1 and 8'h44 if it is 0, with shareability 2 (outer shareable).
- R10: Any other access (`req_acc` 0 read, 1 write, or the unused code 3) gives attribute 8'h00 (device, strongly ordered) and shareability 0 (non-shareable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 64 | Virtual address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 treated as data |
| req_pa_code | input | 3 | Physical address size code |
| req_tbi_lo | input | 1 | Top-byte-ignore enable, lower half |
| req_tbi_hi | input | 1 | Top-byte-ignore enable, upper half |
| req_tbid_lo | input | 1 | Fetch-disable of top-byte-ignore, lower half |
| req_tbid_hi | input | 1 | Fetch-disable of top-byte-ignore, upper half |
| req_dc_force | input | 1 | Force normal write-back data attributes |
| req_dc_tagged | input | 1 | Forced attribute is the tagged variant |
| req_icache_on | input | 1 | Instruction cache enabled |
| req_regime_el1 | input | 1 | Access belongs to the EL1 regime |
| rsp_valid | output | 1 | Result strobe |
| rsp_fault | output | 1 | Level-0 address-size fault |
| rsp_pa | output | 52 | Flat-mapped physical address |
| rsp_perm | output | 3 | Permissions {exec, write, read} |
| rsp_attr | output | 8 | Memory attribute |
| rsp_sh | output | 2 | Shareability code |

## Verification
The assertions check several rules on every cycle. They check the one-cycle strobe and that outputs hold between requests. They check that a faulting result has all other fields cleared and that a passing one has full permissions and the flat address. They also check that addresses below bit 32 never fault, that bits 55:52 always fault, and that each attribute class comes with its shareability. Two kinds of behaviour need the bench's directed scenarios instead. One is the exact fault boundary for each size code, including the half-selected ignore enable and its fetch-only mask. The other is the priority order among forced, fetch and default attributes, shown by pairs of requests that differ in a single control bit.

// File: rtl/xoff_pkg.sv
package xoff_pkg;
  localparam int VA_W   = 64;
  localparam int PA_W   = 52;
  localparam int ATTR_W = 8;
  localparam int SH_W   = 2;
  localparam int PERM_W = 3;
  localparam int TAG_POS = 55;
  localparam int N_CODES = 8;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam logic [ATTR_W-1:0] ATTR_DEVICE    = 8'h00;
  localparam logic [ATTR_W-1:0] ATTR_WB_TAGGED = 8'hF0;
  localparam logic [ATTR_W-1:0] ATTR_WB        = 8'hFF;
  localparam logic [ATTR_W-1:0] ATTR_WT_FETCH  = 8'hEE;
  localparam logic [ATTR_W-1:0] ATTR_NC_FETCH  = 8'h44;

  localparam logic [SH_W-1:0] SH_NONE  = 2'd0;
  localparam logic [SH_W-1:0] SH_OUTER = 2'd2;

  function automatic int unsigned pa_bits_of(input int unsigned code);
    case (code)
      0: return 32;
      1: return 36;
      2: return 40;
      3: return 42;
      4: return 44;
      5: return 48;
      default: return 52;
    endcase
  endfunction
endpackage

// File: rtl/xoff_range_chk.sv
module xoff_range_chk #(
  parameter int VA_W    = 64,
  parameter int TAG_POS = 55,
  parameter int N_CODES = 8
) (
  input  logic [VA_W-1:0]            va,
  input  logic                       is_fetch,
  input  logic [$clog2(N_CODES)-1:0] pa_code,
  input  logic                       tbi_lo,
  input  logic                       tbi_hi,
  input  logic                       tbid_lo,
  input  logic                       tbid_hi,
  output logic                       out_of_range
);
  localparam int TOP_KEEP = TAG_POS + 1;
  localparam logic [VA_W-1:0] TOP_MASK_TBI = {{(VA_W-TOP_KEEP){1'b0}}, {TOP_KEEP{1'b1}}};

  logic [VA_W-1:0] above_pa [N_CODES];

  genvar g;
  generate
    for (g = 0; g < N_CODES; g++) begin : g_lim
      localparam int unsigned BITS = xoff_pkg::pa_bits_of(g);
      assign above_pa[g] = ~((VA_W'(1) << BITS) - VA_W'(1));
    end
  endgenerate

  logic            half_sel;
  logic            tbi_raw;
  logic            tbid_raw;
  logic            tbi_eff;
  logic [VA_W-1:0] top_mask;

  always_comb begin
    half_sel     = va[TAG_POS];
    tbi_raw      = half_sel ? tbi_hi : tbi_lo;
    tbid_raw     = half_sel ? tbid_hi : tbid_lo;
    tbi_eff      = tbi_raw & ~(is_fetch & tbid_raw);
    top_mask     = tbi_eff ? TOP_MASK_TBI : '1;
    out_of_range = |(va & above_pa[pa_code] & top_mask);
  end
endmodule

// File: rtl/xoff_attr_sel.sv
module xoff_attr_sel
  import xoff_pkg::*;
(
  input  logic              is_fetch,
  input  logic              regime_el1,
  input  logic              dc_force,
  input  logic              dc_tagged,
  input  logic              icache_on,
  output logic [ATTR_W-1:0] attr,
  output logic [SH_W-1:0]   sh
);
  always_comb begin
    attr = ATTR_DEVICE;
    sh   = SH_NONE;
    if (regime_el1 && dc_force) begin
      attr = dc_tagged ? ATTR_WB_TAGGED : ATTR_WB;
    end else if (is_fetch) begin
      attr = icache_on ? ATTR_WT_FETCH : ATTR_NC_FETCH;
      sh   = SH_OUTER;
    end
  end
endmodule

// File: rtl/xlat_off_attr_gen.sv
module xlat_off_attr_gen
  import xoff_pkg::*;
#(
  parameter int VA_BITS = xoff_pkg::VA_W,
  parameter int PA_BITS = xoff_pkg::PA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [VA_BITS-1:0] req_va,
  input  logic [1:0]         req_acc,
  input  logic [2:0]         req_pa_code,
  input  logic               req_tbi_lo,
  input  logic               req_tbi_hi,
  input  logic               req_tbid_lo,
  input  logic               req_tbid_hi,
  input  logic               req_dc_force,
  input  logic               req_dc_tagged,
  input  logic               req_icache_on,
  input  logic               req_regime_el1,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [PA_BITS-1:0] rsp_pa,
  output logic [2:0]         rsp_perm,
  output logic [7:0]         rsp_attr,
  output logic [1:0]         rsp_sh
);
  localparam logic [2:0] PERM_ALL = 3'b111;

  logic              is_fetch;
  logic              oor;
  logic [ATTR_W-1:0] attr_c;
  logic [SH_W-1:0]   sh_c;

  assign is_fetch = (acc_e'(req_acc) == ACC_FETCH);

  xoff_range_chk #(
    .VA_W   (VA_BITS),
    .TAG_POS(TAG_POS),
    .N_CODES(N_CODES)
  ) u_range (
    .va          (req_va),
    .is_fetch    (is_fetch),
    .pa_code     (req_pa_code),
    .tbi_lo      (req_tbi_lo),
    .tbi_hi      (req_tbi_hi),
    .tbid_lo     (req_tbid_lo),
    .tbid_hi     (req_tbid_hi),
    .out_of_range(oor)
  );

  xoff_attr_sel u_attr (
    .is_fetch  (is_fetch),
    .regime_el1(req_regime_el1),
    .dc_force  (req_dc_force),
    .dc_tagged (req_dc_tagged),
    .icache_on (req_icache_on),
    .attr      (attr_c),
    .sh        (sh_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pa    <= '0;
      rsp_perm  <= '0;
      rsp_attr  <= '0;
      rsp_sh    <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault <= oor;
        rsp_pa    <= oor ? '0 : req_va[PA_BITS-1:0];
        rsp_perm  <= oor ? '0 : PERM_ALL;
        rsp_attr  <= oor ? '0 : attr_c;
        rsp_sh    <= oor ? '0 : sh_c;
      end
    end
  end
endmodule

// File: rtl/xoff_checker.sv
module xoff_checker (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [63:0] req_va,
  input logic [1:0]  req_acc,
  input logic        req_dc_force,
  input logic        req_regime_el1,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [51:0] rsp_pa,
  input logic [2:0]  rsp_perm,
  input logic [7:0]  rsp_attr,
  input logic [1:0]  rsp_sh
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(rsp_pa) && $stable(rsp_attr) && $stable(rsp_fault)
                   && $stable(rsp_sh) && $stable(rsp_perm));

  assert_low_addr_fits_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_va[63:32] == 32'd0 |=> !rsp_fault);

  assert_mid_bits_fault_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_va[55:52] != 4'd0 |=> rsp_fault);

  assert_fault_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> rsp_pa == '0 && rsp_perm == 3'd0
                               && rsp_attr == 8'd0 && rsp_sh == 2'd0);

  assert_full_perm_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_fault |-> rsp_perm == 3'b111);

  assert_flat_pa_R7: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_fault || rsp_pa == $past(req_va[51:0]));

  assert_forced_attr_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_regime_el1 && req_dc_force |=>
      rsp_fault || (rsp_attr[7:4] == 4'hF && rsp_sh == 2'd0));

  assert_fetch_sh_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_fault && rsp_sh == 2'd2 |-> rsp_attr == 8'hEE || rsp_attr == 8'h44);

  assert_default_attr_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_acc != 2'd2 && !(req_regime_el1 && req_dc_force) |=>
      rsp_attr == 8'h00 && rsp_sh == 2'd0);
endmodule

bind xlat_off_attr_gen xoff_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_va        (req_va),
  .req_acc       (req_acc),
  .req_dc_force  (req_dc_force),
  .req_regime_el1(req_regime_el1),
  .rsp_valid     (rsp_valid),
  .rsp_fault     (rsp_fault),
  .rsp_pa        (rsp_pa),
  .rsp_perm      (rsp_perm),
  .rsp_attr      (rsp_attr),
  .rsp_sh        (rsp_sh)
);

// File: tb/sim_xlat_off_attr_gen.sv
`timescale 1ns/1ps
module sim_xlat_off_attr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [63:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic [2:0]  req_pa_code = '0;
  logic        req_tbi_lo = 0, req_tbi_hi = 0, req_tbid_lo = 0, req_tbid_hi = 0;
  logic        req_dc_force = 0, req_dc_tagged = 0, req_icache_on = 0, req_regime_el1 = 0;
  logic        rsp_valid, rsp_fault;
  logic [51:0] rsp_pa;
  logic [2:0]  rsp_perm;
  logic [7:0]  rsp_attr;
  logic [1:0]  rsp_sh;

  int checks = 0;
  int errors = 0;

  logic        e_valid = 0, e_fault = 0;
  logic [51:0] e_pa = '0;
  logic [2:0]  e_perm = '0;
  logic [7:0]  e_attr = '0;
  logic [1:0]  e_sh = '0;

  always #4 clk = ~clk;

  xlat_off_attr_gen u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va), .req_acc(req_acc),
    .req_pa_code(req_pa_code), .req_tbi_lo(req_tbi_lo), .req_tbi_hi(req_tbi_hi),
    .req_tbid_lo(req_tbid_lo), .req_tbid_hi(req_tbid_hi), .req_dc_force(req_dc_force),
    .req_dc_tagged(req_dc_tagged), .req_icache_on(req_icache_on),
    .req_regime_el1(req_regime_el1), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_pa(rsp_pa), .rsp_perm(rsp_perm), .rsp_attr(rsp_attr), .rsp_sh(rsp_sh)
  );

  function automatic int size_bits(input logic [2:0] code);
    int t[8] = '{32, 36, 40, 42, 44, 48, 52, 52};
    return t[code];
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (rsp_valid !== e_valid || rsp_fault !== e_fault || rsp_pa !== e_pa ||
        rsp_perm !== e_perm || rsp_attr !== e_attr || rsp_sh !== e_sh) begin
      errors++;
      $display("FAIL %s: got v=%0b f=%0b pa=%h perm=%b attr=%h sh=%0d, expected v=%0b f=%0b pa=%h perm=%b attr=%h sh=%0d",
               tag, rsp_valid, rsp_fault, rsp_pa, rsp_perm, rsp_attr, rsp_sh,
               e_valid, e_fault, e_pa, e_perm, e_attr, e_sh);
    end
  endtask

  // ctl = {regime_el1, dc_force, dc_tagged, icache_on, tbid_hi, tbid_lo, tbi_hi, tbi_lo}
  task automatic send(input logic [63:0] va, input logic [1:0] acc,
                      input logic [2:0] code, input logic [7:0] ctl, input string tag);
    int  top;
    bit  tbi, bad, fetch;
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_acc = acc; req_pa_code = code;
    {req_regime_el1, req_dc_force, req_dc_tagged, req_icache_on,
     req_tbid_hi, req_tbid_lo, req_tbi_hi, req_tbi_lo} = ctl;
    fetch = (acc == 2'd2);
    tbi = va[55] ? ctl[1] : ctl[0];
    if (fetch && (va[55] ? ctl[3] : ctl[2])) tbi = 0;
    top = tbi ? 55 : 63;
    bad = 0;
    for (int i = size_bits(code); i <= top; i++) if (va[i]) bad = 1;
    e_valid = 1; e_fault = bad;
    if (bad) begin
      e_pa = '0; e_perm = '0; e_attr = '0; e_sh = '0;
    end else begin
      e_pa = va[51:0]; e_perm = 3'b111;
      if (ctl[7] && ctl[6]) begin e_attr = ctl[5] ? 8'hF0 : 8'hFF; e_sh = 0; end
      else if (fetch)       begin e_attr = ctl[4] ? 8'hEE : 8'h44; e_sh = 2; end
      else                  begin e_attr = 8'h00; e_sh = 0; end
    end
    @(posedge clk); #2;
    compare(tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    req_valid = 1'b0;
    req_va = ~req_va; req_acc = 2'd2; req_regime_el1 = ~req_regime_el1;
    e_valid = 0;
    @(posedge clk); #2;
    compare(tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 compare("R1 reset state");
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #2 compare("R1 first cycle after reset");

    // R3 size boundaries
    send(64'h0000_0000_FFFF_F000, 2'd0, 3'd0, 8'h00, "R3 code0 fits");
    send(64'h0000_0001_0000_0000, 2'd0, 3'd0, 8'h00, "R3 code0 bit32 faults");
    send(64'h0000_000F_FFFF_FFFF, 2'd1, 3'd1, 8'h00, "R3 code1 fits");
    send(64'h0000_0010_0000_0000, 2'd1, 3'd1, 8'h00, "R3 code1 bit36 faults");
    send(64'h0000_0200_0000_0000, 2'd0, 3'd3, 8'h00, "R3 code3 bit41 fits");
    send(64'h0000_0400_0000_0000, 2'd0, 3'd3, 8'h00, "R3 code3 bit42 faults");
    send(64'h0008_0000_0000_0000, 2'd0, 3'd6, 8'h00, "R3 code6 bit51 fits");
    send(64'h000F_FFFF_FFFF_FFFF, 2'd0, 3'd7, 8'h00, "R3 code7 fits");
    send(64'h0000_8000_0000_0000, 2'd0, 3'd4, 8'h00, "R3 code4 bit47 faults");
    send(64'h0000_8000_0000_0000, 2'd0, 3'd5, 8'h00, "R3 code5 bit47 fits");
    // R4 top byte
    send(64'h1000_0000_1234_5678, 2'd0, 3'd0, 8'h01, "R4 low tbi ignores top byte");
    send(64'h1000_0000_1234_5678, 2'd0, 3'd0, 8'h02, "R4 high enable unused for low half");
    send(64'h0080_0000_0000_0000, 2'd0, 3'd6, 8'h03, "R4 bit55 always checked");
    // R5 fetch mask
    send(64'h2000_0000_0000_1000, 2'd2, 3'd0, 8'h05, "R5 fetch with disable faults");
    send(64'h2000_0000_0000_1000, 2'd2, 3'd0, 8'h01, "R5 fetch without disable fits");
    send(64'h2000_0000_0000_1000, 2'd0, 3'd0, 8'h05, "R5 disable ignored on load");
    send(64'h2000_0000_0000_1000, 2'd2, 3'd0, 8'h09, "R5 other half disable ignored");
    // R8 / R9 / R10 attributes
    send(64'h0000_0000_0000_4000, 2'd0, 3'd0, 8'hE0, "R8 forced tagged");
    send(64'h0000_0000_0000_4000, 2'd1, 3'd0, 8'hC0, "R8 forced untagged");
    send(64'h0000_0000_0000_4000, 2'd2, 3'd0, 8'hD0, "R8 force beats fetch");
    send(64'h0000_0000_0000_4000, 2'd0, 3'd0, 8'h60, "R8 ignored outside EL1");
    send(64'h0000_0000_0000_4000, 2'd2, 3'd0, 8'h70, "R9 fetch outside EL1 icache on");
    send(64'h0000_0000_0000_8000, 2'd2, 3'd0, 8'h10, "R9 fetch icache on");
    send(64'h0000_0000_0000_8000, 2'd2, 3'd0, 8'h00, "R9 fetch icache off");
    send(64'h0000_0000_0000_8000, 2'd1, 3'd0, 8'h10, "R10 write default");
    send(64'h0000_0000_0000_8000, 2'd3, 3'd0, 8'h10, "R10 code3 default");
    // R6 fault clears fields, R7 flat map
    send(64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 3'd6, 8'hFF, "R6 fault clears attr");
    send(64'h000A_BCDE_F012_3456, 2'd0, 3'd6, 8'h00, "R7 flat address");
    // R2 timing
    idle("R2 idle holds outputs");
    idle("R2 second idle");
    send(64'h0000_0000_0000_0010, 2'd0, 3'd0, 8'h00, "R2 back to back a");
    send(64'h0000_0000_0000_0020, 2'd2, 3'd0, 8'h10, "R2 back to back b");
    idle("R2 valid drops");

    for (int n = 0; n < 400; n++) begin
      logic [63:0] v;
      v = {$urandom, $urandom};
      case (n % 4)
        0: v[63:32] = '0;
        1: v[55:36] = '0;
        default: ;
      endcase
      send(v, 2'($urandom), 3'($urandom), 8'($urandom), "R7 random mix");
      if (n % 17 == 0) idle("R2 random idle");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule